// File: doc/BRIEF.md
# BLAKE2b Quarter-Round Mixer

This unit performs the BLAKE2b G mixing function on one column or diagonal of the compression state. Each transaction carries four 64-bit state words (a, b, c, d) and the two 64-bit message words (x, y) already chosen by the round schedule. The unit returns the four updated state words. Message selection, round sequencing and column or diagonal addressing belong to the surrounding engine.

The work splits into two half-steps, each consuming one message word. The first half-step uses rotation amounts 32 and 24. The second uses 16 and 63. A register sits after each half-step, so a transaction accepted on one clock edge shows up on the output after the next edge. Both ends use a valid/ready handshake. When the consumer holds off, the pipeline stalls and keeps its contents.

Top module: `blake2b_g_pipe`

## Requirements
- R1: The first half-step computes a1 = a + b + x, d1 = rotr(d ^ a1, 32), c1 = c + d1 and b1 = rotr(b ^ c1, 24).
- R2: The second half-step starts from the first half-step's results and uses y: a2 = a1 + b1 + y, d2 = rotr(d1 ^ a2, 16), c2 = c1 + d2 and b2 = rotr(b1 ^ c2, 63). The outputs are a2, b2, c2 and d2.
- R3: Every addition wraps modulo 2^64, and carries out of bit 63 are discarded.
- R4: The 63-bit right rotation equals a 1-bit left rotation: bit 63 of the operand lands in bit 0 of the result, and bit k lands in bit k+1.
- R5: The 24-bit and 16-bit rotations move whole bytes. Byte i of the result, counting byte 0 as bits 7:0, is operand byte (i+3) mod 8 for the 24-bit rotation and operand byte (i+2) mod 8 for the 16-bit rotation.
- R6: Suppose a transaction is accepted (in_valid and in_ready high) at a clock edge, the pipeline is empty and out_ready is high. Then out_valid is low after that edge and high after the next edge, carrying that transaction's result.
- R7: While out_valid is high and out_ready is low, out_valid and all four output words keep their values. No transaction is lost or duplicated across stalls, and results leave in acceptance order.
- R8: in_ready is high in every cycle in which out_ready is high.
- R9: A synchronous active-high reset clears both pipeline stages. After a reset edge, out_valid is low and in_ready is high, and nothing that was in flight appears later.
- R10: All-zero state and message words produce all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An input transaction is offered |
| in_ready | output | 1 | The unit can take a transaction this cycle |
| in_a | input | 64 | State word a |
| in_b | input | 64 | State word b |
| in_c | input | 64 | State word c |
| in_d | input | 64 | State word d |
| in_x | input | 64 | Message word used by the first half-step |
| in_y | input | 64 | Message word used by the second half-step |
| out_valid | output | 1 | A result is offered |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_a | output | 64 | Updated a |
| out_b | output | 64 | Updated b |
| out_c | output | 64 | Updated c |
| out_d | output | 64 | Updated d |

## Verification
A walking single bit is applied to each of the six input words in turn. This shows which rotation and which addition a given input bit passes through, so a wrong rotation amount, a swapped message word or a misrouted operand shows up at a distinct bit position. All-ones and mixed-saturation operands exercise carries out of bit 63, which separates wrapping sums from widened ones. Hashed pseudo-random words exercise every byte lane of the 16-bit, 24-bit and 63-bit rotations at once. The whole sweep runs a second time with out_ready toggling pseudo-randomly, which exposes lost, repeated or reordered results and outputs that drift during a stall.

// File: rtl/blake2b_g_pipe.sv
module blake2b_g_pipe (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_a,
  input  logic [63:0] in_b,
  input  logic [63:0] in_c,
  input  logic [63:0] in_d,
  input  logic [63:0] in_x,
  input  logic [63:0] in_y,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_a,
  output logic [63:0] out_b,
  output logic [63:0] out_c,
  output logic [63:0] out_d
);
  localparam int W = 64;

  function automatic logic [W-1:0] rotr(input logic [W-1:0] v, input int n);
    return (v >> n) | (v << (W - n));
  endfunction

  function automatic logic [4*W-1:0] half(input logic [W-1:0] a, b, c, d, m,
                                         input int rd, input int rb);
    logic [W-1:0] na, nb, nc, nd;
    na = a + b + m;
    nd = rotr(d ^ na, rd);
    nc = c + nd;
    nb = rotr(b ^ nc, rb);
    return {na, nb, nc, nd};
  endfunction

  logic           s1_v, s2_v, s2_ready;
  logic [4*W-1:0] s1_st, s2_st;
  logic [W-1:0]   s1_y;
  logic [4*W-1:0] h1, h2;

  assign s2_ready = !s2_v || out_ready;
  assign in_ready = !s1_v || s2_ready;

  assign h1 = half(in_a, in_b, in_c, in_d, in_x, 32, 24);
  assign h2 = half(s1_st[4*W-1:3*W], s1_st[3*W-1:2*W], s1_st[2*W-1:W],
                   s1_st[W-1:0], s1_y, 16, 63);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      if (in_ready) s1_v <= in_valid;
      if (s2_ready) s2_v <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) begin
      s1_st <= h1;
      s1_y  <= in_y;
    end
    if (s2_ready && s1_v) s2_st <= h2;
  end

  assign out_valid = s2_v;
  assign {out_a, out_b, out_c, out_d} = s2_st;
endmodule

module g_pipe_checks (
  input logic        clk,
  input logic        rst,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_a,
  input logic [63:0] out_b,
  input logic [63:0] out_c,
  input logic [63:0] out_d
);
  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> !out_valid && in_ready);

  assert_valid_held_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid);

  assert_data_held_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> $stable(out_a) && $stable(out_b) &&
                                $stable(out_c) && $stable(out_d));

  assert_ready_follows_R8: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);
endmodule

bind blake2b_g_pipe g_pipe_checks u_g_pipe_checks (.*);

// File: tb/test_blake2b_g_pipe.sv
module test_blake2b_g_pipe;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [63:0] in_a = '0, in_b = '0, in_c = '0, in_d = '0, in_x = '0, in_y = '0;
  logic [63:0] out_a, out_b, out_c, out_d;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  localparam int N = 489;

  always #2.5 clk = ~clk;

  blake2b_g_pipe i_blake2b_g_pipe (.*);

  function automatic logic [63:0] mix(input logic [63:0] s);
    logic [63:0] z;
    z = (s + 64'h1) * 64'h9E3779B97F4A7C15;
    z = (z ^ (z >> 30)) * 64'hBF58476D1CE4E5B9;
    return z ^ (z >> 27);
  endfunction

  function automatic logic [63:0] byterot(input logic [63:0] v, input int k);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = v[8*((i + k) % 8) +: 8];
    return r;
  endfunction

  function automatic logic [255:0] model(input logic [383:0] v);
    logic [63:0] a, b, c, d, x, y;
    {a, b, c, d, x, y} = v;
    a = a + b + x;  d = d ^ a; d = {d[31:0], d[63:32]};
    c = c + d;      b = byterot(b ^ c, 3);
    a = a + b + y;  d = byterot(d ^ a, 2);
    c = c + d;      b = b ^ c; b = {b[62:0], b[63]};
    return {a, b, c, d};
  endfunction

  function automatic logic [383:0] gen(input int i);
    logic [383:0] v;
    v = '0;
    if (i >= 1 && i <= 384)
      v[(5 - (i - 1) / 64) * 64 + (i - 1) % 64] = 1'b1;
    else if (i == 385) v = '1;
    else if (i == 386) v = {{128{1'b1}}, 256'h0};
    else if (i == 387) v = {64'h1, 192'h0, {128{1'b1}}};
    else if (i == 388) v = {64'h0, 64'h1, {128{1'b1}}, 128'h0};
    else if (i > 388)
      for (int k = 0; k < 6; k++) v[64*k +: 64] = mix(64'(i * 8 + k));
    return v;
  endfunction

  function automatic string tag(input int i);
    if (i == 0) return "R10";
    if (i <= 384) return "R1 R2";
    if (i <= 388) return "R3";
    return "R4 R5";
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_sweep(input bit stall);
    logic [255:0] exq[$];
    int tq[$];
    logic [255:0] held;
    bit hold = 1'b0;
    int idx = 0, cyc = 0;
    while (idx < N || exq.size() != 0) begin
      @(negedge clk);
      out_ready = stall ? (mix(64'(cyc + 7000)) [7:6] != 2'b00) : 1'b1;
      if (hold)
        check(out_valid && {out_a, out_b, out_c, out_d} == held, "R7",
              {out_a, out_b, out_c, out_d}, held);
      in_valid = (idx < N);
      {in_a, in_b, in_c, in_d, in_x, in_y} = gen(idx);
      #1;
      if (out_ready) check(in_ready, "R8", 256'(in_ready), 256'd1);
      if (out_valid && out_ready) begin
        if (exq.size() == 0) check(1'b0, "R7", {out_a, out_b, out_c, out_d}, '0);
        else begin
          logic [255:0] e;
          int t;
          e = exq.pop_front();
          t = tq.pop_front();
          check({out_a, out_b, out_c, out_d} == e, tag(t),
                {out_a, out_b, out_c, out_d}, e);
        end
      end
      hold = out_valid && !out_ready;
      held = {out_a, out_b, out_c, out_d};
      if (in_valid && in_ready) begin
        exq.push_back(model(gen(idx)));
        tq.push_back(idx);
        idx++;
      end
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(!out_valid && in_ready, "R9", {out_valid, in_ready}, 256'd1);

    in_valid = 1'b1;
    {in_a, in_b, in_c, in_d, in_x, in_y} = '0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(!out_valid, "R6", 256'(out_valid), 256'd0);
    @(posedge clk);
    @(negedge clk);
    check(out_valid, "R6", 256'(out_valid), 256'd1);
    check({out_a, out_b, out_c, out_d} == '0, "R10", {out_a, out_b, out_c, out_d}, '0);
    @(posedge clk);

    run_sweep(1'b0);
    run_sweep(1'b1);

    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    check(out_valid, "R7", 256'(out_valid), 256'd1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b1;
    check(!out_valid && in_ready, "R9", {out_valid, in_ready}, 256'd1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R9", 256'(out_valid), 256'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule